// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

This block is a memory-mapped pulse-width modulator with four independent outputs. A plain 32-bit register port gives access to a shared control word, a period count and a duty count for each channel, and one shared word that packs the four clock prescalers. Each channel first divides the input clock by its prescale value plus one. It then runs a 16-bit counter that returns to zero once it has counted `period` ticks. The output is active while the counter is below the duty count, and a per-channel polarity bit sets the active level.

To reconfigure a channel, software clears its enable bit, writes the new counts and enables the channel again. While the channel is disabled, its prescaler and counter are held at zero, so every enable starts a clean period. While a channel runs, new period, duty and prescale values take effect only at the next period boundary. This means no shortened or merged pulse is produced. Each channel's drive-type bit is stored and made available on a port for the pad logic.

Top module: `pwm4_ctrl`

## Requirements
- R1: After reset, the control word at offset 0x00 reads 0x00000F00 (polarity bits set, enable and type bits clear). Every other register reads 0, and pwm_o is 4'b0000.
- R2: The control word keeps the enable bits in bits 3:0, polarity in bits 11:8 and drive type in bits 18:15. Channel ch has its period at offset 0x04+8*ch and its duty at offset 0x08+8*ch, each in bits 15:0. Unused bits read 0, and offsets that map to no register read 0.
- R3: drive_type_o[ch] always equals control bit 15+ch.
- R4: An enabled channel with prescale p, period count P >= 2 and duty count D < P repeats every (p+1)*P clocks. It is active for the first (p+1)*D clocks of each period, starting in the first cycle after the enabling write.
- R5: The prescale word at offset 0x24 holds channel ch's 6-bit field at bits (3-ch)*6+5 : (3-ch)*6, so channel 0 uses bits 23:18 and channel 3 uses bits 5:0. Bits 31:24 read 0.
- R6: A duty count of 0 keeps the output inactive. A duty count >= the period count keeps it active.
- R7: When polarity bit 8+ch is 1, the active level of pwm_o[ch] is high. When it is 0, the active level is low.
- R8: A disabled channel drives its inactive level: low for polarity 1, high for polarity 0. Its prescaler and counter are held at zero, so enabling it starts a new period.
- R9: While a channel is enabled, new period, duty or prescale writes take effect only when the counter wraps. While it is disabled, they take effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Register byte offset |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pwm_o | output | 4 | PWM outputs, one per channel |
| drive_type_o | output | 4 | Stored drive-type bit for each channel |

## Verification
The bench uses the default parameters: four channels, 16-bit counts and 6-bit prescalers. With these values, every one of the four packed prescale fields is exercised, including the largest prescale of 63.

A table of vectors rotates through the channels and covers the following cases:
- several combinations of prescale, period and duty;
- both polarities;
- a duty of zero;
- a duty equal to the period;
- a duty above the period;
- the smallest period of 2.

For each vector, the bench counts active samples over exactly two output periods. Directed tests then cover the following:
- reset values;
- masking of unused bits;
- holes in the address map;
- the idle levels;
- a duty write in the middle of a period, which must wait for the wrap.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  localparam int NUM_CH  = 4;
  localparam int CNT_W   = 16;
  localparam int PSC_W   = 6;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 32;
  localparam int POL_LSB = 8;
  localparam int TYP_LSB = 15;
  localparam int CTRL_OFF = 'h00;
  localparam int PSC_OFF  = 'h24;

  function automatic int per_off(int ch);
    return 'h04 + 8 * ch;
  endfunction

  function automatic int dty_off(int ch);
    return 'h08 + 8 * ch;
  endfunction

  // channel 0 sits in the most significant field
  function automatic int psc_lsb(int ch);
    return (NUM_CH - 1 - ch) * PSC_W;
  endfunction
endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
  import pwm4_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   wr_en_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [NUM_CH-1:0]      en_o,
  output logic [NUM_CH-1:0]      pol_o,
  output logic [NUM_CH-1:0]      typ_o,
  output logic [NUM_CH-1:0][CNT_W-1:0] per_o,
  output logic [NUM_CH-1:0][CNT_W-1:0] dty_o,
  output logic [NUM_CH-1:0][PSC_W-1:0] psc_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] PSC_A  = ADDR_W'(PSC_OFF);

  logic ctrl_we, psc_we;
  assign ctrl_we = wr_en_i && (addr_i == CTRL_A);
  assign psc_we  = wr_en_i && (addr_i == PSC_A);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= '0;
      pol_o <= '1;
      typ_o <= '0;
    end else if (ctrl_we) begin
      en_o  <= wdata_i[NUM_CH-1:0];
      pol_o <= wdata_i[POL_LSB +: NUM_CH];
      typ_o <= wdata_i[TYP_LSB +: NUM_CH];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] PER_A = ADDR_W'(per_off(c));
    localparam logic [ADDR_W-1:0] DTY_A = ADDR_W'(dty_off(c));
    localparam int                PL    = psc_lsb(c);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        per_o[c] <= '0;
        dty_o[c] <= '0;
        psc_o[c] <= '0;
      end else begin
        if (wr_en_i && addr_i == PER_A) per_o[c] <= wdata_i[CNT_W-1:0];
        if (wr_en_i && addr_i == DTY_A) dty_o[c] <= wdata_i[CNT_W-1:0];
        if (psc_we)                     psc_o[c] <= wdata_i[PL +: PSC_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_A) begin
      rdata_o[NUM_CH-1:0]         = en_o;
      rdata_o[POL_LSB +: NUM_CH]  = pol_o;
      rdata_o[TYP_LSB +: NUM_CH]  = typ_o;
    end
    if (addr_i == PSC_A) begin
      for (int c = 0; c < NUM_CH; c++) rdata_o[psc_lsb(c) +: PSC_W] = psc_o[c];
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ADDR_W'(per_off(c))) rdata_o[CNT_W-1:0] = per_o[c];
      if (addr_i == ADDR_W'(dty_off(c))) rdata_o[CNT_W-1:0] = dty_o[c];
    end
  end

  // R2: a write to an unmapped offset leaves the control word alone
  assert_ctrl_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i != CTRL_A) |=> $stable(en_o) && $stable(pol_o) && $stable(typ_o));
endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan
  import pwm4_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pol_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] dty_i,
  output logic             pwm_o
);
  logic [PSC_W-1:0] psc_q, psc_w;
  logic [CNT_W-1:0] cnt_q, per_w, dty_w;
  logic             tick, wrap, active;

  assign tick = (psc_q == psc_w);
  assign wrap = (per_w <= CNT_W'(1)) || (cnt_q >= per_w - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q <= '0;
      cnt_q <= '0;
      psc_w <= '0;
      per_w <= '0;
      dty_w <= '0;
    end else if (!en_i) begin
      // held idle; working copies follow registers directly
      psc_q <= '0;
      cnt_q <= '0;
      psc_w <= psc_i;
      per_w <= per_i;
      dty_w <= dty_i;
    end else if (tick) begin
      psc_q <= '0;
      if (wrap) begin
        cnt_q <= '0;
        psc_w <= psc_i;
        per_w <= per_i;
        dty_w <= dty_i;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end else begin
      psc_q <= psc_q + PSC_W'(1);
    end
  end

  assign active = (cnt_q < dty_w);
  assign pwm_o  = en_i ? (pol_i ? active : !active) : !pol_i;

  assert_idle_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0) && (psc_q == '0));
  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && per_w >= CNT_W'(2)) |-> cnt_q < per_w);
  assert_psc_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> psc_q <= psc_w);
  assert_shadow_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q != '0) |-> $stable(dty_w) && $stable(per_w));
endmodule

// File: rtl/pwm4_ctrl.sv
module pwm4_ctrl
  import pwm4_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [5:0]        addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [3:0]        pwm_o,
  output logic [3:0]        drive_type_o
);
  logic [NUM_CH-1:0]            en, pol, typ;
  logic [NUM_CH-1:0][CNT_W-1:0] per, dty;
  logic [NUM_CH-1:0][PSC_W-1:0] psc;

  pwm4_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .en_o    (en),
    .pol_o   (pol),
    .typ_o   (typ),
    .per_o   (per),
    .dty_o   (dty),
    .psc_o   (psc)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm4_chan u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en[c]),
      .pol_i  (pol[c]),
      .psc_i  (psc[c]),
      .per_i  (per[c]),
      .dty_i  (dty[c]),
      .pwm_o  (pwm_o[c])
    );
  end

  assign drive_type_o = typ;
endmodule

// File: tb/sim_pwm4_ctrl.sv
module sim_pwm4_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm, dtype;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  pwm4_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm), .drive_type_o(dtype)
  );

  // {psc[6], per[16], dty[16], pol[1], expected active-high samples[16]}
  localparam int NV = 8;
  localparam logic [54:0] VEC [NV] = '{
    {6'd0,  16'd10, 16'd3, 1'b1, 16'd6},
    {6'd1,  16'd8,  16'd5, 1'b1, 16'd20},
    {6'd2,  16'd5,  16'd0, 1'b1, 16'd0},
    {6'd0,  16'd6,  16'd9, 1'b1, 16'd12},
    {6'd0,  16'd7,  16'd2, 1'b0, 16'd10},
    {6'd3,  16'd4,  16'd4, 1'b1, 16'd32},
    {6'd0,  16'd2,  16'd1, 1'b1, 16'd2},
    {6'd63, 16'd3,  16'd1, 1'b1, 16'd128}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic measure(int ch, int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm[ch]) hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(6'h00, d); check("R1 ctrl", d, 32'h0000_0F00);
    rd(6'h0C, d); check("R1 period ch1", d, 0);
    rd(6'h24, d); check("R1 prescale", d, 0);
    check("R1 pwm_o", {28'd0, pwm}, 0);
    check("R1 drive_type_o", {28'd0, dtype}, 0);

    // R2 masking and holes
    wr(6'h14, 32'hABCD_1234); rd(6'h14, d); check("R2 period ch2", d, 32'h1234);
    wr(6'h20, 32'hFFFF_5AA5); rd(6'h20, d); check("R2 duty ch3", d, 32'h5AA5);
    rd(6'h28, d); check("R2 unmapped 0x28", d, 0);
    wr(6'h3C, 32'hFFFF_FFFF); rd(6'h3C, d); check("R2 unmapped 0x3C", d, 0);
    rd(6'h00, d); check("R2 ctrl after hole write", d, 32'h0000_0F00);
    wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, d); check("R2 ctrl mask", d, 32'h0007_8F0F);
    check("R3 drive_type_o all", {28'd0, dtype}, 32'hF);
    wr(6'h00, 32'h0001_0000); check("R3 drive_type_o ch1", {28'd0, dtype}, 32'h2);

    // R5 prescale packing
    wr(6'h24, 32'hFFFF_FFFF); rd(6'h24, d); check("R5 prescale mask", d, 32'h00FF_FFFF);
    wr(6'h24, 32'h00FC_0000); rd(6'h24, d); check("R5 ch0 field top", d, 32'h00FC_0000);

    // R8 idle levels
    wr(6'h00, 32'h0000_0000); check("R8 idle inverted", {28'd0, pwm}, 32'hF);
    wr(6'h00, 32'h0000_0F00); check("R8 idle normal", {28'd0, pwm}, 32'h0);

    // table: R4, R5, R6, R7, R8 restart on enable
    for (int v = 0; v < NV; v++) begin
      int ch, p, per, dty, w;
      logic pol;
      ch  = v % 4;
      p   = int'(VEC[v][54:49]);
      per = int'(VEC[v][48:33]);
      dty = int'(VEC[v][32:17]);
      pol = VEC[v][16];
      w   = 2 * (p + 1) * per;
      wr(6'h00, 32'h0000_0F00);
      wr(6'h24, 32'(p) << ((3 - ch) * 6));
      wr(6'(4 + 8 * ch), 32'(per));
      wr(6'(8 + 8 * ch), 32'(dty));
      wr(6'h00, (32'h0000_0F00 & ~(32'(!pol) << (8 + ch))) | (32'd1 << ch));
      measure(ch, w, hi);
      check($sformatf("R4 R6 R7 vector %0d ch%0d", v, ch), 32'(hi), 32'(VEC[v][15:0]));
    end
    wr(6'h00, 32'h0000_0F00);
    check("R8 all disabled low", {28'd0, pwm}, 0);

    // R9 mid-period duty write waits for wrap
    wr(6'h24, 0);
    wr(6'h04, 10);
    wr(6'h08, 3);
    wr(6'h00, 32'h0000_0F01);
    measure(0, 7, hi);
    check("R9 first part", 32'(hi), 3);
    wr(6'h08, 10);
    measure(0, 1, hi);
    check("R9 old duty kept", 32'(hi), 0);
    measure(0, 10, hi);
    check("R9 new duty after wrap", 32'(hi), 10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule